// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block watches the command pins of a two-bank synchronous DRAM and keeps its own model of what each bank is doing. It decodes every command, tracks each bank through idle, row active, write recovery (with or without auto precharge), precharge, refresh and mode-register access, and times the exits from those states with counters set by parameters. It also checks the command against activate-to-column, activate-to-precharge and activate-to-activate spacing.

A command that is not allowed in the state of the bank it selects is reported with a one-cycle error pulse and a 4-bit code. Such a command has no effect on the model, and the model keeps running its timers. Commands are evaluated only when the clock enable was high on the previous clock. The monitor sits beside a memory controller in simulation or on silicon as a protocol watchdog. It drives nothing on the memory bus.

Top module: `sdram_bank_monitor`

## Requirements
- R1: Commands decode from active-low pins. cs_n high is deselect. With cs_n low, {ras_n,cas_n,we_n} = 111 is no-op, 110 is burst stop, 101 is read, 100 is write, 011 is activate, 010 is precharge, 001 is refresh and 000 is mode-register load. Deselect and no-op never raise an error.
- R2: After a synchronous reset, both banks report idle and err_valid is low. Bank states are reported on bank_state, with bank 0 in bits [2:0] and bank 1 in bits [5:3]. The codes are idle=0, row active=1, write recovering=2, write recovering with auto precharge=3, precharge=4, refreshing=5 and mode-register access=6.
- R3: A write to a row-active bank enters write recovering (A10 low) for T_DPL cycles, after which the bank is row active again. In that state, read and write are legal: A10 high selects auto precharge, read returns the bank to row active (or to precharge with A10), and write restarts recovery. Activate, precharge, refresh and mode load are busy errors.
- R4: A write with A10 high enters write recovering with auto precharge for T_DPL cycles, then precharge. Precharge lasts T_RP cycles, then the bank is idle. In both states, everything except deselect, no-op and burst stop is a busy error.
- R5: Refresh with both banks idle puts both banks in refreshing for T_RC cycles, then idle. Any command other than deselect, no-op or burst stop is a busy error in that state.
- R6: Mode load with both banks idle puts both banks in mode-register access for 2 cycles, then idle. Burst stop and every other command except deselect and no-op is a busy error in that state.
- R7: A command in a cycle whose previous-cycle cke was low is ignored. It raises no error and changes no bank state.
- R8: Bank-directed commands are judged on the bank selected by ba. A precharge with A10 high targets both banks: each row-active bank enters precharge, and idle banks stay idle.
- R9: An activate to a bank other than the last activated one, fewer than T_RRD cycles after that activate, is an error with rule code 6.
- R10: A read or write to a row-active bank fewer than T_RCD cycles after its activate is an error with rule code 4. Exactly T_RCD cycles later, it is legal.
- R11: A precharge to a row-active bank fewer than T_RAS cycles after its activate is an error with rule code 5. Exactly T_RAS cycles later, it is legal.
- R12: An error appears as err_valid high for one cycle, in the cycle after the offending command edge. err_code[3] holds the bank and err_code[2:0] holds the rule: busy=1, row already open=2, no open row=3, tRCD=4, tRAS=5, tRRD=6, not all idle=7. The offending command leaves the state unchanged.
- R13: Activate to a row-active bank gives rule 2. Read or write to an idle bank gives rule 3. Refresh or mode load while any bank is not idle gives rule 7, naming the lowest non-idle bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 4 | {bank, rule} of the last error |
| bank_state | output | 6 | Per-bank state codes, bank 0 in the low bits |

## Verification
The bench places commands exactly on the cycle where a timing limit runs out: a read T_RCD cycles after activate, and a precharge T_RAS cycles after activate. An off-by-one counter would flag the read or the precharge, or let through the command one cycle earlier. The bench also probes each timed state on the last cycle before it exits, so a timer that exits a cycle early or late shows up as a wrong state code. A command issued after cke was low, which would otherwise be a no-open-row error, catches a monitor that does not gate on the previous clock enable. Busy errors raised inside recovery, refresh and mode access confirm that an illegal command does not corrupt the model while the exit timer keeps counting.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int NB     = 2;
  localparam int BA_W   = 1;
  localparam int ST_W   = 3;
  localparam int CODE_W = BA_W + 3;

  typedef enum logic [3:0] {
    C_DESL, C_NOP, C_BST, C_READ, C_WRIT, C_ACT, C_PRE, C_REF, C_MRS
  } cmd_e;

  typedef enum logic [ST_W-1:0] {
    S_IDLE    = 3'd0,
    S_ACTIVE  = 3'd1,
    S_WREC    = 3'd2,
    S_WREC_AP = 3'd3,
    S_PRECHG  = 3'd4,
    S_REFRESH = 3'd5,
    S_MRSACC  = 3'd6
  } bstate_e;

  typedef enum logic [3:0] {
    A_NONE, A_OPEN, A_RD, A_RDA, A_WR, A_WRA, A_PRE, A_REF, A_MRS
  } bact_e;

  localparam logic [2:0] E_BUSY     = 3'd1;
  localparam logic [2:0] E_ROW_OPEN = 3'd2;
  localparam logic [2:0] E_NO_ROW   = 3'd3;
  localparam logic [2:0] E_TRCD     = 3'd4;
  localparam logic [2:0] E_TRAS     = 3'd5;
  localparam logic [2:0] E_TRRD     = 3'd6;
  localparam logic [2:0] E_NOT_IDLE = 3'd7;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sbm_cmd_decode.sv
module sbm_cmd_decode
  import sbm_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NOP;
    if (cs_n) begin
      cmd = C_DESL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111: cmd = C_NOP;
        3'b110: cmd = C_BST;
        3'b101: cmd = C_READ;
        3'b100: cmd = C_WRIT;
        3'b011: cmd = C_ACT;
        3'b010: cmd = C_PRE;
        3'b001: cmd = C_REF;
        default: cmd = C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sbm_bank_fsm.sv
module sbm_bank_fsm
  import sbm_pkg::*;
#(
  parameter int T_DPL = 2,
  parameter int T_RP  = 2,
  parameter int T_RC  = 6,
  parameter int T_MRD = 2,
  parameter int T_RCD = 2,
  parameter int T_RAS = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  bact_e   act,
  output bstate_e state,
  output logic    rcd_ok,
  output logic    ras_ok
);
  localparam int TMAX = imax(imax(T_DPL, T_RP), imax(T_RC, T_MRD));
  localparam int TW   = imax(1, $clog2(TMAX + 1));
  localparam int CMAX = imax(T_RCD, T_RAS);
  localparam int CW   = imax(1, $clog2(CMAX + 1));

  logic [TW-1:0] tmr;
  logic [CW-1:0] age;

  // cycles since this bank's last activate, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      age <= CW'(CMAX);
    end else if (act == A_OPEN) begin
      age <= CW'(1);
    end else if (age != CW'(CMAX)) begin
      age <= age + CW'(1);
    end
  end

  assign rcd_ok = (age >= CW'(T_RCD));
  assign ras_ok = (age >= CW'(T_RAS));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      tmr   <= '0;
    end else begin
      case (act)
        A_OPEN: state <= S_ACTIVE;
        A_RD:   state <= S_ACTIVE;
        A_RDA:  begin state <= S_PRECHG;  tmr <= TW'(T_RP - 1);  end
        A_WR:   begin state <= S_WREC;    tmr <= TW'(T_DPL - 1); end
        A_WRA:  begin state <= S_WREC_AP; tmr <= TW'(T_DPL - 1); end
        A_PRE:  begin state <= S_PRECHG;  tmr <= TW'(T_RP - 1);  end
        A_REF:  begin state <= S_REFRESH; tmr <= TW'(T_RC - 1);  end
        A_MRS:  begin state <= S_MRSACC;  tmr <= TW'(T_MRD - 1); end
        default: begin
          case (state)
            S_WREC: begin
              if (tmr == '0) state <= S_ACTIVE;
              else           tmr <= tmr - TW'(1);
            end
            S_WREC_AP: begin
              if (tmr == '0) begin
                state <= S_PRECHG;
                tmr   <= TW'(T_RP - 1);
              end else begin
                tmr <= tmr - TW'(1);
              end
            end
            S_PRECHG, S_REFRESH, S_MRSACC: begin
              if (tmr == '0) state <= S_IDLE;
              else           tmr <= tmr - TW'(1);
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  assert_wrec_exit_R3: assert property (@(posedge clk) disable iff (rst)
    state == S_WREC |=> (state == S_WREC || state == S_WREC_AP ||
                         state == S_ACTIVE || state == S_PRECHG));
  assert_wrecap_exit_R4: assert property (@(posedge clk) disable iff (rst)
    state == S_WREC_AP |=> (state == S_WREC_AP || state == S_PRECHG));
  assert_refresh_exit_R5: assert property (@(posedge clk) disable iff (rst)
    state == S_REFRESH |=> (state == S_REFRESH || state == S_IDLE));
  assert_mrs_exit_R6: assert property (@(posedge clk) disable iff (rst)
    state == S_MRSACC |=> (state == S_MRSACC || state == S_IDLE));
endmodule

// File: rtl/sbm_rule_check.sv
module sbm_rule_check
  import sbm_pkg::*;
(
  input  cmd_e              cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  input  bstate_e           st     [NB],
  input  logic              rcd_ok [NB],
  input  logic              ras_ok [NB],
  input  logic              rrd_ok,
  input  logic [BA_W-1:0]   last_ba,
  output bact_e             act    [NB],
  output logic              illegal,
  output logic [CODE_W-1:0] code
);
  logic [2:0]      rule;
  logic [BA_W-1:0] bsel;
  bstate_e         s;
  bact_e           col_act;

  always_comb begin
    for (int b = 0; b < NB; b++) act[b] = A_NONE;
    illegal = 1'b0;
    rule    = 3'd0;
    bsel    = ba;
    s       = st[ba];
    if (cmd == C_READ) col_act = a10 ? A_RDA : A_RD;
    else               col_act = a10 ? A_WRA : A_WR;

    case (cmd)
      C_BST: begin
        if (s == S_MRSACC) begin illegal = 1'b1; rule = E_BUSY; end
      end
      C_READ, C_WRIT: begin
        case (s)
          S_IDLE:   begin illegal = 1'b1; rule = E_NO_ROW; end
          S_ACTIVE: begin
            if (!rcd_ok[ba]) begin illegal = 1'b1; rule = E_TRCD; end
            else act[ba] = col_act;
          end
          S_WREC:   act[ba] = col_act;
          default:  begin illegal = 1'b1; rule = E_BUSY; end
        endcase
      end
      C_ACT: begin
        case (s)
          S_IDLE: begin
            if (ba != last_ba && !rrd_ok) begin illegal = 1'b1; rule = E_TRRD; end
            else act[ba] = A_OPEN;
          end
          S_ACTIVE: begin illegal = 1'b1; rule = E_ROW_OPEN; end
          default:  begin illegal = 1'b1; rule = E_BUSY; end
        endcase
      end
      C_PRE: begin
        for (int b = 0; b < NB; b++) begin
          if (!illegal && (a10 || BA_W'(b) == ba)) begin
            if (st[b] == S_ACTIVE && !ras_ok[b]) begin
              illegal = 1'b1; rule = E_TRAS; bsel = BA_W'(b);
            end else if (st[b] != S_ACTIVE && st[b] != S_IDLE) begin
              illegal = 1'b1; rule = E_BUSY; bsel = BA_W'(b);
            end
          end
        end
        if (!illegal) begin
          for (int b = 0; b < NB; b++)
            if ((a10 || BA_W'(b) == ba) && st[b] == S_ACTIVE) act[b] = A_PRE;
        end
      end
      C_REF, C_MRS: begin
        for (int b = 0; b < NB; b++) begin
          if (!illegal && st[b] != S_IDLE) begin
            illegal = 1'b1; rule = E_NOT_IDLE; bsel = BA_W'(b);
          end
        end
        if (!illegal) begin
          for (int b = 0; b < NB; b++) act[b] = (cmd == C_REF) ? A_REF : A_MRS;
        end
      end
      default: ;
    endcase
    code = {bsel, rule};
  end
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sbm_pkg::*;
#(
  parameter int T_DPL = 2,
  parameter int T_RP  = 2,
  parameter int T_RC  = 6,
  parameter int T_MRD = 2,
  parameter int T_RCD = 2,
  parameter int T_RAS = 5,
  parameter int T_RRD = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic                 err_valid,
  output logic [CODE_W-1:0]    err_code,
  output logic [NB*ST_W-1:0]   bank_state
);
  localparam int RW = imax(1, $clog2(T_RRD + 1));

  logic              cke_q;
  cmd_e              cmd_raw, cmd;
  bstate_e           st     [NB];
  logic              rcd_ok [NB];
  logic              ras_ok [NB];
  bact_e             act    [NB];
  logic              illegal;
  logic [CODE_W-1:0] code;
  logic [RW-1:0]     rrd_cnt;
  logic [BA_W-1:0]   last_ba;
  logic              rrd_ok;
  logic              any_open;

  sbm_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd_raw)
  );

  // clock enable low on the previous edge suspends command evaluation
  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end
  assign cmd = cke_q ? cmd_raw : C_NOP;

  assign rrd_ok = (rrd_cnt >= RW'(T_RRD));

  sbm_rule_check u_rules (
    .cmd(cmd), .ba(ba), .a10(a10), .st(st), .rcd_ok(rcd_ok), .ras_ok(ras_ok),
    .rrd_ok(rrd_ok), .last_ba(last_ba), .act(act), .illegal(illegal), .code(code)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sbm_bank_fsm #(
      .T_DPL(T_DPL), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
      .T_RCD(T_RCD), .T_RAS(T_RAS)
    ) u_bank (
      .clk(clk), .rst(rst), .act(act[g]),
      .state(st[g]), .rcd_ok(rcd_ok[g]), .ras_ok(ras_ok[g])
    );
    assign bank_state[g*ST_W +: ST_W] = st[g];
  end

  always_comb begin
    any_open = 1'b0;
    for (int b = 0; b < NB; b++) if (act[b] == A_OPEN) any_open = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_cnt <= RW'(T_RRD);
      last_ba <= '0;
    end else if (any_open) begin
      rrd_cnt <= RW'(1);
      last_ba <= ba;
    end else if (rrd_cnt != RW'(T_RRD)) begin
      rrd_cnt <= rrd_cnt + RW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_code  <= '0;
    end else begin
      err_valid <= illegal;
      if (illegal) err_code <= code;
    end
  end

  assert_err_has_rule_R12: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> err_code[2:0] != 3'd0);
  assert_err_needs_select_R1: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(!cs_n));
  assert_cke_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !cke_q |=> !err_valid);
  assert_rrd_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    (any_open && ba != last_ba) |-> rrd_ok);
endmodule

// File: tb/sdram_bank_monitor_bench.sv
module sdram_bank_monitor_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [0:0] ba = 1'b0;
  logic       a10 = 1'b0;
  logic       err_valid;
  logic [3:0] err_code;
  logic [5:0] bank_state;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_bank_monitor u_sdram_bank_monitor (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err_valid(err_valid), .err_code(err_code),
    .bank_state(bank_state)
  );

  localparam logic [3:0] K_DSL = 4'd0, K_NOP = 4'd1, K_BST = 4'd2, K_RD = 4'd3,
                         K_WR = 4'd4, K_ACT = 4'd5, K_PRE = 4'd6, K_REF = 4'd7,
                         K_MRS = 4'd8;

  // {req, cmd, ba, a10, cke, exp_err, exp_code, exp_s0, exp_s1}
  localparam int NV = 46;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1,  K_ACT, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd0},  // R1 activate b0
    {4'd9,  K_ACT, 1'b1,1'b0,1'b1, 1'b1,4'hE, 3'd1,3'd0},  // R9 too soon
    {4'd10, K_RD,  1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd0},  // R10 exactly tRCD
    {4'd9,  K_ACT, 1'b1,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd1},  // R9 spacing met
    {4'd10, K_WR,  1'b1,1'b0,1'b1, 1'b1,4'hC, 3'd1,3'd1},  // R10 early write
    {4'd3,  K_WR,  1'b1,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd2},  // R3 enter recovery
    {4'd3,  K_ACT, 1'b1,1'b0,1'b1, 1'b1,4'h9, 3'd1,3'd2},  // R3 busy, last cycle
    {4'd3,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd1},  // R3 back to active
    {4'd4,  K_WR,  1'b0,1'b1,1'b1, 1'b0,4'h0, 3'd3,3'd1},  // R4 write w/ AP
    {4'd4,  K_RD,  1'b0,1'b0,1'b1, 1'b1,4'h1, 3'd3,3'd1},  // R4 busy
    {4'd4,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd4,3'd1},  // R4 precharge
    {4'd4,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd4,3'd1},
    {4'd4,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd1},  // R4 idle after tRP
    {4'd13, K_RD,  1'b0,1'b0,1'b1, 1'b1,4'h3, 3'd0,3'd1},  // R13 no open row
    {4'd8,  K_PRE, 1'b1,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd4},  // R8 single bank
    {4'd13, K_REF, 1'b0,1'b0,1'b1, 1'b1,4'hF, 3'd0,3'd4},  // R13 not all idle
    {4'd4,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd0},
    {4'd5,  K_REF, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd5,3'd5},  // R5 refresh
    {4'd5,  K_ACT, 1'b0,1'b0,1'b1, 1'b1,4'h1, 3'd5,3'd5},  // R5 busy
    {4'd5,  K_BST, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd5,3'd5},  // R5 stop harmless
    {4'd5,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd5,3'd5},
    {4'd5,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd5,3'd5},
    {4'd5,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd5,3'd5},  // R5 last cycle
    {4'd5,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd0},  // R5 idle after tRC
    {4'd6,  K_MRS, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd6,3'd6},  // R6 mode load
    {4'd6,  K_BST, 1'b0,1'b0,1'b1, 1'b1,4'h1, 3'd6,3'd6},  // R6 stop illegal
    {4'd6,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd0},  // R6 two clocks
    {4'd1,  K_ACT, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd0},  // R1
    {4'd11, K_PRE, 1'b0,1'b0,1'b1, 1'b1,4'h5, 3'd1,3'd0},  // R11 early precharge
    {4'd13, K_ACT, 1'b0,1'b0,1'b1, 1'b1,4'h2, 3'd1,3'd0},  // R13 row open
    {4'd11, K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd0},
    {4'd11, K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd1,3'd0},
    {4'd8,  K_PRE, 1'b1,1'b1,1'b1, 1'b0,4'h0, 3'd4,3'd0},  // R8 all banks, R11 exactly tRAS
    {4'd8,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd4,3'd0},
    {4'd8,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd0},
    {4'd7,  K_NOP, 1'b0,1'b0,1'b0, 1'b0,4'h0, 3'd0,3'd0},  // R7 drop cke
    {4'd7,  K_ACT, 1'b0,1'b0,1'b0, 1'b0,4'h0, 3'd0,3'd0},  // R7 ignored
    {4'd7,  K_RD,  1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd0},  // R7 still ignored
    {4'd7,  K_RD,  1'b0,1'b0,1'b1, 1'b1,4'h3, 3'd0,3'd0},  // R7 live again
    {4'd1,  K_DSL, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd0},  // R1 deselect
    {4'd9,  K_ACT, 1'b1,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd1},  // R9
    {4'd3,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd1},
    {4'd3,  K_WR,  1'b1,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd2},  // R3
    {4'd3,  K_RD,  1'b1,1'b1,1'b1, 1'b0,4'h0, 3'd0,3'd4},  // R3 read w/ AP
    {4'd3,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd4},
    {4'd3,  K_NOP, 1'b0,1'b0,1'b1, 1'b0,4'h0, 3'd0,3'd0}
  };

  task automatic drive(input logic [3:0] k, input logic b, input logic a, input logic ck);
    cke = ck; ba = b; a10 = a;
    case (k)
      K_DSL:   {cs_n, ras_n, cas_n, we_n} = 4'b1011;
      K_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      K_BST:   {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      K_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      K_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      K_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      K_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      K_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
    endcase
  endtask

  task automatic check(input int req, input logic ev, input logic [3:0] ec,
                       input logic [2:0] s0, input logic [2:0] s1);
    checks++;
    if (err_valid !== ev || (ev && err_code !== ec) || bank_state !== {s1, s0}) begin
      errors++;
      $display("FAIL R%0d: got err=%b code=%h st=%h, expected err=%b code=%h st=%h",
               req, err_valid, err_code, bank_state, ev, ec, {s1, s0});
    end
  endtask

  task automatic step(input logic [3:0] k, input logic b, input logic a, input logic ck);
    drive(k, b, a, ck);
    @(posedge clk); #1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    drive(K_NOP, 1'b0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check(2, 1'b0, 4'h0, 3'd0, 3'd0);  // R2 reset state

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17:14], VEC[i][13], VEC[i][12], VEC[i][11]);
      check(int'(VEC[i][21:18]), VEC[i][10], VEC[i][9:6], VEC[i][5:3], VEC[i][2:0]);
    end

    // R12 error is a single-cycle pulse and the state is untouched
    step(K_WR, 1'b1, 1'b0, 1'b1);
    check(12, 1'b1, 4'hB, 3'd0, 3'd0);
    step(K_NOP, 1'b0, 1'b0, 1'b1);
    check(12, 1'b0, 4'h0, 3'd0, 3'd0);

    // R2 reset in the middle of an open row
    step(K_ACT, 1'b0, 1'b0, 1'b1);
    check(2, 1'b0, 4'h0, 3'd1, 3'd0);
    rst = 1'b1;
    step(K_NOP, 1'b0, 1'b0, 1'b1);
    rst = 1'b0;
    check(2, 1'b0, 4'h0, 3'd0, 3'd0);
    // R13 after reset the row is closed again
    step(K_RD, 1'b0, 1'b0, 1'b1);
    check(13, 1'b1, 4'h3, 3'd0, 3'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule